// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block runs on the audio master clock. From it, the block makes the two timing signals that a serial audio link needs: a bit clock, and a frame clock that marks the left and right channel halves. The bit clock is the master clock divided by 2 or by 4. The frame clock is not counted from the master clock directly. It is a further division of the bit clock by 32, 64 or 128. This keeps the two outputs in a fixed phase relation, so every frame-clock transition lands on a falling edge of the bit clock.

A single configuration write carries all of the following:
- the bit-clock divide select;
- a two-bit frame divide code;
- a serial enable that starts and stops both generated clocks together;
- a separate master-clock enable, which is presented on an output for the gate that drives the master clock to the external converter.

A divide change written while the clocks run is held back and applied at the next frame boundary. This way no frame is ever cut short or stretched.

Top module: `audio_serial_clkgen`

## Requirements
- R1: When the bit-divide select is 0, the bit clock toggles on every master-clock cycle (divide by 2). When the select is 1, it toggles every second cycle (divide by 4). The duty cycle is 50% in both cases.
- R2: The frame divide code selects the frame period in bit-clock periods: code 0 gives 32, code 1 gives 64, code 2 gives 128. The frame clock spends half of each period low and half high.
- R3: The frame clock changes level only in a cycle where the bit clock falls from 1 to 0.
- R4: A write carrying frame code 3 leaves the stored frame ratio unchanged. The bit-divide select and both enables in that same write still take effect.
- R5: The bit clock and the frame clock run only while both the serial enable and the master-clock enable are set; otherwise both are 0. The master-enable output shows the written master-enable bit from the cycle after the write.
- R6: After the clocks are enabled, or re-enabled after a stop, the first master-clock cycle shows both outputs at 0. The frame therefore opens with the frame clock low, which marks the left channel.
- R7: A divide setting written while the clocks run takes effect at the next frame boundary. A write made in the last cycle of a frame applies to the frame that starts next.
- R8: During and right after reset, all three outputs are 0. The settings are divide by 2, frame code 0, and both enables off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Strobe: load the configuration fields this cycle |
| cfgSerialEn | input | 1 | Enable for the bit and frame clocks |
| cfgMclkEn | input | 1 | Master-clock enable bit |
| cfgBitDiv4 | input | 1 | 0: bit clock = master/2, 1: master/4 |
| cfgFrameCode | input | 2 | 0: /32, 1: /64, 2: /128 of bit clock, 3: rejected |
| mclkOn | output | 1 | Stored master-clock enable, for an external gate |
| bitClk | output | 1 | Generated bit clock |
| frameClk | output | 1 | Generated frame (left/right) clock, low = left |

## Verification
A configuration write and a frame boundary can fall in the same master-clock cycle. In that case the block must choose between the new setting and the old one for the frame that is just starting. The bench provokes this coincidence deliberately: it follows its own frame-position model and issues the write exactly in the cycle its model marks as the last of a frame. It then judges every following cycle of both clocks against a reference computed with the new ratios from position zero. Random writes sprinkled over long runs reach the same coincidence by chance, along with writes that disable the clocks at a boundary.

// File: rtl/asclk_pkg.sv
package asclk_pkg;

  // Divide settings as held by the control register.
  typedef struct packed {
    logic       div4;       // 1: bit clock = master / 4
    logic [1:0] frameCode;  // 0:/32 1:/64 2:/128 of bit clock
  } divCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic hold;   // clocks stopped: clear counter, force outputs low
    logic wrap;   // last cycle of a frame: restart counter
  } dpStrobe_t;

  localparam logic [1:0] FRAME_CODE_BAD = 2'd3;

endpackage

// File: rtl/asclk_ctrl.sv
module asclk_ctrl
  import asclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic       cfgSerialEn,
  input  logic       cfgMclkEn,
  input  logic       cfgBitDiv4,
  input  logic [1:0] cfgFrameCode,
  input  logic       frameEnd,
  output divCfg_t    activeCfg,
  output dpStrobe_t  strb,
  output logic       mclkOn
);

  logic    regSerialEn;
  logic    regMclkEn;
  divCfg_t pendCfg;
  divCfg_t pendNext;
  logic    running;

  assign running = regSerialEn & regMclkEn;
  assign mclkOn  = regMclkEn;

  // Pending settings after this cycle's write; an illegal frame code keeps the old ratio.
  always_comb begin
    pendNext = pendCfg;
    if (cfgWrite) begin
      pendNext.div4 = cfgBitDiv4;
      if (cfgFrameCode != FRAME_CODE_BAD) pendNext.frameCode = cfgFrameCode;
    end
  end

  always_comb begin
    strb.hold = ~running;
    strb.wrap = running & frameEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regSerialEn <= 1'b0;
      regMclkEn   <= 1'b0;
      pendCfg     <= '0;
      activeCfg   <= '0;
    end else begin
      if (cfgWrite) begin
        regSerialEn <= cfgSerialEn;
        regMclkEn   <= cfgMclkEn;
      end
      pendCfg <= pendNext;
      // Stopped: follow at once. Running: only at the frame boundary.
      if (!running || frameEnd) activeCfg <= pendNext;
    end
  end

  // R4: a rejected frame code never alters the stored ratio
  a_r4_code3_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgFrameCode == FRAME_CODE_BAD) |=> (pendCfg.frameCode == $past(pendCfg.frameCode)));

  // R7: while running, the live setting only moves across a frame boundary
  a_r7_cfg_held_mid_frame: assert property (@(posedge clk) disable iff (!rstN)
    ($past(running) && !$past(frameEnd)) |-> $stable(activeCfg));

  // R5: the serial clocks are held whenever either enable is off
  a_r5_hold_without_enables: assert property (@(posedge clk) disable iff (!rstN)
    (!regSerialEn || !regMclkEn) |-> (strb.hold && !strb.wrap));

endmodule

// File: rtl/asclk_datapath.sv
module asclk_datapath
  import asclk_pkg::*;
#(
  parameter int MIN_FRAME_LOG2 = 5,   // smallest frame ratio is 2**MIN_FRAME_LOG2
  parameter int FRAME_STEPS    = 3,   // number of legal frame ratios, doubling each
  parameter int MAX_DIV_LOG2   = 2    // largest bit divide is 2**MAX_DIV_LOG2
) (
  input  logic      clk,
  input  logic      rstN,
  input  divCfg_t   cfg,
  input  dpStrobe_t strb,
  output logic      frameEnd,
  output logic      bitClk,
  output logic      frameClk
);

  localparam int CNT_W = MIN_FRAME_LOG2 + FRAME_STEPS - 1 + MAX_DIV_LOG2;
  localparam int IDX_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodMask;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] periodLog2;

  // One counter spans a whole frame; both clocks are bits of it.
  always_comb begin
    bitIdx     = cfg.div4 ? IDX_W'(1) : IDX_W'(0);
    periodLog2 = IDX_W'(MIN_FRAME_LOG2) + IDX_W'(cfg.frameCode) + bitIdx + IDX_W'(1);
    periodMask = (CNT_W'(1) << periodLog2) - CNT_W'(1);
    frameEnd   = &(cnt | ~periodMask);
    bitClk     = ~strb.hold & cnt[bitIdx];
    frameClk   = ~strb.hold & cnt[periodLog2 - IDX_W'(1)];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      cnt <= '0;
    else if (strb.hold || strb.wrap) cnt <= '0;
    else                            cnt <= cnt + CNT_W'(1);
  end

  // R3: frame clock moves only with a falling bit clock
  a_r3_frame_on_bit_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hold && $past(!strb.hold) && (frameClk != $past(frameClk)))
      |-> ($past(bitClk) && !bitClk));

  // R1: divide-by-2 bit clock toggles every cycle
  a_r1_div2_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hold && $past(!strb.hold) && !cfg.div4 && $past(!cfg.div4))
      |-> (bitClk != $past(bitClk)));

  // R6: the counter restarts from zero when clocks resume
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.hold) |-> (cnt == '0));

  // R2: every frame opens low on both clocks
  a_r2_frame_opens_low: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrap) |-> (!bitClk && !frameClk));

endmodule

// File: rtl/audio_serial_clkgen.sv
module audio_serial_clkgen
  import asclk_pkg::*;
#(
  parameter int MIN_FRAME_LOG2 = 5,
  parameter int FRAME_STEPS    = 3,
  parameter int MAX_DIV_LOG2   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic       cfgSerialEn,
  input  logic       cfgMclkEn,
  input  logic       cfgBitDiv4,
  input  logic [1:0] cfgFrameCode,
  output logic       mclkOn,
  output logic       bitClk,
  output logic       frameClk
);

  divCfg_t   activeCfg;
  dpStrobe_t strb;
  logic      frameEnd;

  asclk_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrite     (cfgWrite),
    .cfgSerialEn  (cfgSerialEn),
    .cfgMclkEn    (cfgMclkEn),
    .cfgBitDiv4   (cfgBitDiv4),
    .cfgFrameCode (cfgFrameCode),
    .frameEnd     (frameEnd),
    .activeCfg    (activeCfg),
    .strb         (strb),
    .mclkOn       (mclkOn)
  );

  asclk_datapath #(
    .MIN_FRAME_LOG2 (MIN_FRAME_LOG2),
    .FRAME_STEPS    (FRAME_STEPS),
    .MAX_DIV_LOG2   (MAX_DIV_LOG2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (activeCfg),
    .strb     (strb),
    .frameEnd (frameEnd),
    .bitClk   (bitClk),
    .frameClk (frameClk)
  );

endmodule

// File: tb/audio_serial_clkgen_test.sv
`timescale 1ns/1ps
module audio_serial_clkgen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrite = 1'b0;
  logic       cfgSerialEn = 1'b0;
  logic       cfgMclkEn = 1'b0;
  logic       cfgBitDiv4 = 1'b0;
  logic [1:0] cfgFrameCode = 2'd0;
  logic       mclkOn, bitClk, frameClk;

  always #2.5 clk = ~clk;

  audio_serial_clkgen uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSerialEn(cfgSerialEn),
    .cfgMclkEn(cfgMclkEn), .cfgBitDiv4(cfgBitDiv4), .cfgFrameCode(cfgFrameCode),
    .mclkOn(mclkOn), .bitClk(bitClk), .frameClk(frameClk)
  );

  // Reference model state (register values after the last edge)
  bit    mRun, mSEn, mMEn, aDiv4, pDiv4;
  int    aCode, pCode, mPh;
  int    nVec, nBad;
  string curReq = "R8";
  bit    prevBit, prevFrame, prevRun;

  function automatic int periodOf(bit d4, int code);
    return (d4 ? 4 : 2) * (32 << code);
  endfunction

  function automatic bit expBit(bit d4, int ph);
    return d4 ? bit'((ph / 2) % 2) : bit'(ph % 2);
  endfunction

  function automatic bit expFrame(bit d4, int code, int ph);
    return bit'((ph / (periodOf(d4, code) / 2)) % 2);
  endfunction

  task automatic checkNow();
    bit eb, ef;
    eb = mRun ? expBit(aDiv4, mPh) : 1'b0;
    ef = mRun ? expFrame(aDiv4, aCode, mPh) : 1'b0;
    nVec++;
    if (bitClk !== eb) begin
      nBad++; $display("FAIL %s bitClk got %0b exp %0b (pos %0d)", curReq, bitClk, eb, mPh);
    end
    nVec++;
    if (frameClk !== ef) begin
      nBad++; $display("FAIL %s frameClk got %0b exp %0b (pos %0d)", curReq, frameClk, ef, mPh);
    end
    nVec++;
    if (mclkOn !== mMEn) begin
      nBad++; $display("FAIL R5 mclkOn got %0b exp %0b", mclkOn, mMEn);
    end
    // R3: frame transitions only alongside a bit-clock fall
    if (mRun && prevRun && (frameClk != prevFrame)) begin
      nVec++;
      if (!(prevBit && !bitClk)) begin
        nBad++; $display("FAIL R3 bit edge got %0b->%0b exp 1->0", prevBit, bitClk);
      end
    end
    prevBit = bitClk; prevFrame = frameClk; prevRun = mRun;
  endtask

  task automatic step(bit wr, bit se, bit me, bit d4, logic [1:0] code);
    bit fe, nd4;
    int nc;
    checkNow();
    cfgWrite = wr; cfgSerialEn = se; cfgMclkEn = me; cfgBitDiv4 = d4; cfgFrameCode = code;
    @(posedge clk);
    fe  = mRun && (mPh == periodOf(aDiv4, aCode) - 1);
    nd4 = wr ? d4 : pDiv4;
    nc  = (wr && code != 2'd3) ? int'(code) : pCode;
    if (!mRun || fe) begin aDiv4 = nd4; aCode = nc; mPh = 0; end
    else mPh++;
    pDiv4 = nd4; pCode = nc;
    if (wr) begin mSEn = se; mMEn = me; end
    mRun = mSEn && mMEn;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL R1 watchdog expired got running exp finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R8: reset state
    @(negedge clk); checkNow();
    @(negedge clk); checkNow();
    rstN = 1'b1;
    idle(3);

    // R5: one enable alone keeps clocks low; mclkOn follows its bit
    curReq = "R5";
    step(1, 1, 0, 0, 2'd0); idle(100);
    step(1, 0, 1, 0, 2'd0); idle(100);

    // R6 then R1: start from a stop
    curReq = "R6";
    step(1, 1, 1, 0, 2'd0); idle(3);
    curReq = "R1"; idle(300);

    // R2: every legal ratio with both bit divides
    curReq = "R2";
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 3; c++) begin
        step(1, 0, 1, bit'(d), 2'(c));
        step(1, 1, 1, bit'(d), 2'(c));
        idle(2 * periodOf(bit'(d), c) + 10);
      end
    end

    // R4: code 3 while running and while stopped
    curReq = "R4";
    step(1, 0, 1, 0, 2'd1); step(1, 1, 1, 0, 2'd1); idle(50);
    step(1, 1, 1, 1, 2'd3); idle(2 * periodOf(1, 1) + 20);
    step(1, 0, 1, 0, 2'd3); idle(5);
    step(1, 1, 1, 0, 2'd3); idle(periodOf(0, 1) + 20);

    // R7: change mid-frame, then exactly in the last cycle of a frame
    curReq = "R7";
    idle(37);
    step(1, 1, 1, 1, 2'd2); idle(periodOf(1, 2) + 40);
    while (!(mRun && mPh == periodOf(aDiv4, aCode) - 1)) idle(1);
    step(1, 1, 1, 0, 2'd0); idle(3 * periodOf(0, 0));

    // R6: stop mid-frame and restart
    curReq = "R6";
    idle(21);
    step(1, 0, 1, 0, 2'd0); idle(10);
    step(1, 1, 1, 0, 2'd0); idle(80);

    // Random writes over long runs
    curReq = "R7";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 40 == 0)
        step(1, ($urandom % 8) != 0, ($urandom % 8) != 0, bit'($urandom % 2), 2'($urandom % 4));
      else
        idle(1);
    end

    summary();
    $finish;
  end

endmodule